// File: doc/BRIEF.md
# Audio PWM Modulator with Dither

This block turns a stream of signed audio samples into a pulse-width-modulated carrier. A free-running up-counter sets the carrier period. Each incoming sample is moved into offset binary, so that mid-scale means silence. The top bits of the result become an unsigned duty value. A pseudo-random offset of one least significant bit can be added, with the result held within range. The block drives two outputs that are always inverses of each other, so a bridge-tied load sees a differential swing.

Samples come in through a valid/ready handshake at the audio rate, which is far slower than the carrier rate. An accepted sample waits in a shadow register. It reaches the active duty register only when the counter wraps. A carrier period therefore never changes duty part-way through. The last duty value repeats for as many periods as it takes the next sample to arrive.

Top module: `pwm_audio_modulator`

## Requirements
- R1: The carrier counter counts up by one per clock from 0 to 2^DUTY_W-1 and then returns to 0, so a carrier period lasts exactly 2^DUTY_W clocks.
- R2: With dither off, a sample becomes a duty value in two steps. First the sign bit of the 16-bit sample is inverted, which is the same as adding 32768. Then the top DUTY_W bits are taken, which is the same as shifting right by 16-DUTY_W. The most negative sample gives 0, zero gives 2^(DUTY_W-1), and the most positive sample gives 2^DUTY_W-1.
- R3: pwmA is high exactly while the counter is below the active duty value. A duty of 0 keeps pwmA low for the whole period. A duty of 2^DUTY_W-1 holds pwmA high for all counts but one.
- R4: The dither source is a 16-bit LFSR. It is seeded with 0xACE1 at reset and shifts left, feeding in bit15^bit13^bit12^bit10. It advances once per accepted sample and at no other time. When ditherEn is high at acceptance, the duty value gets an offset taken from the two LFSR bits [1:0] present before that advance: 2'b01 adds one, 2'b10 subtracts one, and any other value leaves the duty unchanged.
- R5: A dithered duty value is held within the range: it stays at 0 when one is subtracted from 0, and at 2^DUTY_W-1 when one is added to 2^DUTY_W-1.
- R6: pwmB is the inverse of pwmA in every cycle.
- R7: A sample is accepted on a clock edge where sampleValid and sampleReady are both high, and its duty value then goes into the shadow register. The active duty value changes only at the edge where the counter goes from its maximum to 0, and only when the shadow holds a sample that has not yet been moved. Otherwise the active duty value repeats.
- R8: sampleReady is high while the shadow is empty. It goes low in the cycle after an acceptance and returns high in the cycle after the shadow moves to the active register. Data offered while sampleReady is low is ignored.
- R9: After reset the counter is 0, the active duty value is 2^(DUTY_W-1), so the output starts at silence, the shadow is empty and sampleReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Offered sample is valid |
| sampleData | input | SAMPLE_W | Signed two's-complement audio sample |
| ditherEn | input | 1 | Adds LFSR dither to the sample being accepted |
| sampleReady | output | 1 | Shadow register can take a sample |
| pwmA | output | 1 | PWM output, high while counter < active duty |
| pwmB | output | 1 | Inverse of pwmA for the bridge load |

## Verification
The bench builds the block with DUTY_W set to 6 and SAMPLE_W left at 16, so a carrier period lasts 64 clocks and the conversion shift is 10. This short period lets hundreds of sample transfers, with backpressure on the handshake and both saturation edges under dither, fit into a short run. It also keeps every behaviour that depends on resolution in play: the wrap-time load, the constant-low duty of 0, and the single low count at full scale.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic accept;      // a sample is taken into the shadow this edge
    logic loadActive;  // the shadow moves to the active duty this edge
  } dpStrobe_t;

  localparam int LFSR_W = 16;

endpackage

// File: rtl/pwm_audio_ctrl.sv
module pwm_audio_ctrl
  import pwm_audio_pkg::*;
#(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic [DUTY_W-1:0] carrierCount,
  output dpStrobe_t         strobe
);

  localparam logic [DUTY_W-1:0] COUNT_MAX = '1;

  logic shadowFull;
  logic atWrap;

  assign atWrap            = (carrierCount == COUNT_MAX);
  assign sampleReady       = ~shadowFull;
  assign strobe.accept     = sampleValid & ~shadowFull;
  assign strobe.loadActive = shadowFull & atWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrierCount <= '0;
      shadowFull   <= 1'b0;
    end else begin
      carrierCount <= carrierCount + 1'b1;
      if (strobe.loadActive) begin
        shadowFull <= 1'b0;
      end else if (strobe.accept) begin
        shadowFull <= 1'b1;
      end
    end
  end

  // R1: after the top count the counter restarts at zero
  assert_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    atWrap |=> (carrierCount == '0));

  // R8: an accepted sample closes the handshake for the next cycle
  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> !sampleReady);

  // R8: the handshake reopens once the shadow has moved on
  assert_ready_reopen_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadActive |=> sampleReady);

  // R7: a load is only ever issued at the wrap
  assert_load_at_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadActive |=> (carrierCount == '0));

endmodule

// File: rtl/pwm_audio_datapath.sv
module pwm_audio_datapath
  import pwm_audio_pkg::*;
#(
  parameter int               SAMPLE_W  = 16,
  parameter int               DUTY_W    = 10,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                ditherEn,
  input  logic [DUTY_W-1:0]   carrierCount,
  output logic                pwmA,
  output logic                pwmB
);

  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;
  localparam logic [DUTY_W-1:0] DUTY_MID = DUTY_W'(1) << (DUTY_W - 1);

  logic [SAMPLE_W-1:0] offsetSample;
  logic [DUTY_W-1:0]   baseDuty;
  logic [DUTY_W-1:0]   ditheredDuty;
  logic [DUTY_W-1:0]   shadowDuty;
  logic [DUTY_W-1:0]   activeDuty;
  logic [LFSR_W-1:0]   lfsrState;
  logic                lfsrFeed;
  logic                stepUp;
  logic                stepDown;

  // Offset binary: flipping the sign bit adds half of full scale
  assign offsetSample = {~sampleData[SAMPLE_W-1], sampleData[SAMPLE_W-2:0]};

  generate
    if (DUTY_W <= SAMPLE_W) begin : g_truncate
      assign baseDuty = offsetSample[SAMPLE_W-1 -: DUTY_W];
    end else begin : g_widen
      assign baseDuty = {offsetSample, {(DUTY_W - SAMPLE_W){1'b0}}};
    end
  endgenerate

  // Dither offset from the two low LFSR bits
  assign stepUp   = ditherEn & (lfsrState[1:0] == 2'b01);
  assign stepDown = ditherEn & (lfsrState[1:0] == 2'b10);

  always_comb begin
    ditheredDuty = baseDuty;
    if (stepUp && (baseDuty != DUTY_MAX)) begin
      ditheredDuty = baseDuty + 1'b1;
    end else if (stepDown && (baseDuty != '0)) begin
      ditheredDuty = baseDuty - 1'b1;
    end
  end

  assign lfsrFeed = lfsrState[15] ^ lfsrState[13] ^ lfsrState[12] ^ lfsrState[10];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrState  <= LFSR_SEED;
      shadowDuty <= DUTY_MID;
      activeDuty <= DUTY_MID;
    end else begin
      if (strobe.accept) begin
        lfsrState  <= {lfsrState[LFSR_W-2:0], lfsrFeed};
        shadowDuty <= ditheredDuty;
      end
      if (strobe.loadActive) begin
        activeDuty <= shadowDuty;
      end
    end
  end

  assign pwmA = (carrierCount < activeDuty);
  assign pwmB = ~pwmA;

  // R7: the shadow only changes on an acceptance
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accept |=> $stable(shadowDuty));

  // R7: the active duty only changes on a load strobe
  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadActive |=> $stable(activeDuty));

  // R4: a stored duty lies within one step of the undithered value
  assert_dither_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.accept |=> ((shadowDuty == $past(baseDuty)) ||
                       (shadowDuty == $past(baseDuty) + 1'b1) ||
                       (shadowDuty == $past(baseDuty) - 1'b1)));

  // R4: the LFSR never falls into the all-zero state
  assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0);

  // R6: the bridge outputs are always opposite
  assert_complement_R6: assert property (@(posedge clk) disable iff (!rstN)
    pwmA != pwmB);

  // R3: zero duty keeps the output low
  assert_zero_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (activeDuty == '0) |-> !pwmA);

endmodule

// File: rtl/pwm_audio_modulator.sv
module pwm_audio_modulator
  import pwm_audio_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DUTY_W   = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                ditherEn,
  output logic                sampleReady,
  output logic                pwmA,
  output logic                pwmB
);

  dpStrobe_t         strobe;
  logic [DUTY_W-1:0] carrierCount;

  pwm_audio_ctrl #(
    .DUTY_W(DUTY_W)
  ) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .sampleValid  (sampleValid),
    .sampleReady  (sampleReady),
    .carrierCount (carrierCount),
    .strobe       (strobe)
  );

  pwm_audio_datapath #(
    .SAMPLE_W  (SAMPLE_W),
    .DUTY_W    (DUTY_W),
    .LFSR_SEED (16'hACE1)
  ) datapath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .sampleData   (sampleData),
    .ditherEn     (ditherEn),
    .carrierCount (carrierCount),
    .pwmA         (pwmA),
    .pwmB         (pwmB)
  );

endmodule

// File: tb/pwm_audio_modulator_tb_top.sv
`timescale 1ns/1ps
module pwm_audio_modulator_tb_top;

  localparam int SW     = 16;
  localparam int DW     = 6;
  localparam int PERIOD = 1 << DW;
  localparam int SHIFT  = SW - DW;
  localparam int DMAX   = PERIOD - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          ditherEn = 1'b0;
  logic          sampleReady;
  logic          pwmA;
  logic          pwmB;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pwm_audio_modulator #(.SAMPLE_W(SW), .DUTY_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .ditherEn(ditherEn), .sampleReady(sampleReady), .pwmA(pwmA), .pwmB(pwmB)
  );

  // Functions derived from the requirements
  function automatic int convDuty(logic [SW-1:0] s);
    return int'((s ^ 16'h8000) >> SHIFT);
  endfunction

  function automatic int ditherOf(logic [15:0] l);
    if (l[1:0] == 2'b01) return 1;
    if (l[1:0] == 2'b10) return -1;
    return 0;
  endfunction

  function automatic int satDuty(int v);
    if (v < 0) return 0;
    if (v > DMAX) return DMAX;
    return v;
  endfunction

  function automatic logic [15:0] lfsrNext(logic [15:0] l);
    return {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
  endfunction

  // Reference state
  int          mCnt;
  int          mShadow;
  int          mActive;
  bit          mFull;
  logic [15:0] mLfsr;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCnt <= 0; mShadow <= PERIOD / 2; mActive <= PERIOD / 2;
      mFull <= 1'b0; mLfsr <= 16'hACE1;
    end else begin
      mCnt <= (mCnt + 1) % PERIOD;
      if (mFull && mCnt == DMAX) begin
        mActive <= mShadow;
        mFull   <= 1'b0;
      end else if (sampleValid && !mFull) begin
        mShadow <= ditherEn ? satDuty(convDuty(sampleData) + ditherOf(mLfsr))
                            : convDuty(sampleData);
        mFull   <= 1'b1;
        mLfsr   <= lfsrNext(mLfsr);
      end
    end
  end

  task automatic check(bit cond, string tag, int act, int exp);
    vectors++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock, compared at the falling edge against the reference
  task automatic step();
    @(negedge clk);
    check(pwmA == (mCnt < mActive), "R1 R3 R7 pwmA", int'(pwmA), int'(mCnt < mActive));
    check(pwmB == !(mCnt < mActive), "R6 pwmB", int'(pwmB), int'(!(mCnt < mActive)));
    check(sampleReady == !mFull, "R8 sampleReady", int'(sampleReady), int'(!mFull));
  endtask

  task automatic sendSample(logic [SW-1:0] d, bit dith);
    while (!sampleReady) step();
    sampleValid = 1'b1; sampleData = d; ditherEn = dith;
    step();
    sampleValid = 1'b0;
    check(sampleReady == 1'b0, "R8 ready low after accept", int'(sampleReady), 0);
  endtask

  // Counts high clocks over the next full period and compares
  task automatic measure(int exp, string tag);
    int hi = 0;
    while (mCnt != 0) step();
    for (int k = 0; k < PERIOD; k++) begin
      if (pwmA) hi++;
      step();
    end
    check(hi == exp, tag, hi, exp);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    step();
    check(sampleReady == 1'b1, "R9 ready after reset", int'(sampleReady), 1);
    measure(PERIOD / 2, "R9 silent start duty");

    sendSample(16'h7FFF, 1'b0); measure(DMAX, "R1 R2 full scale");
    sendSample(16'h8000, 1'b0); measure(0, "R2 R3 zero duty");
    sendSample(16'h0000, 1'b0); measure(PERIOD / 2, "R2 mid scale");
    sendSample(16'h0400, 1'b0); measure(PERIOD / 2 + 1, "R2 one above mid");
    sendSample(16'hFFFF, 1'b0); measure(PERIOD / 2 - 1, "R2 just below mid");

    // Hold: no new sample, the same duty repeats
    for (int k = 0; k < 3; k++) measure(PERIOD / 2 - 1, "R7 duty repeats");

    // Saturation under dither at both ends
    for (int k = 0; k < 8; k++) begin
      int e;
      e = satDuty(DMAX + ditherOf(mLfsr));
      sendSample(16'h7FFF, 1'b1); measure(e, "R4 R5 top saturation");
      e = satDuty(0 + ditherOf(mLfsr));
      sendSample(16'h8000, 1'b1); measure(e, "R4 R5 bottom saturation");
    end

    // Random traffic with backpressure, data changes while blocked
    for (int c = 0; c < 40000; c++) begin
      int r;
      sampleValid = ($urandom % 3) == 0;
      r = $urandom % 8;
      case (r)
        0: sampleData = 16'h7FFF;
        1: sampleData = 16'h8000;
        2: sampleData = 16'h0000;
        3: sampleData = 16'hFFFF;
        default: sampleData = SW'($urandom);
      endcase
      if (($urandom % 16) == 0) ditherEn = ~ditherEn;
      step();
    end
    sampleValid = 1'b0;
    measure(mActive, "R7 R8 final duty");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule